// File: doc/BRIEF.md
# Feedback-Row Montgomery Modular Multiplier

This block forms the Montgomery product of two operands, A and B, modulo an odd modulus M. All three arrive one radix-2^W digit at a time. The hardware is one digit cell and one quotient-digit generator. They are used once per digit position and once per pass. Every partial-product digit the cell produces is written straight back into the partial-product store, one position lower. The next pass therefore reads the shifted partial product as its input, digit by digit. After NDIG+1 passes the block streams out the final partial product, least significant digit first. The extra pass consumes an implicit zero top digit of A.

The caller supplies the quotient inverse digit w = (r - M[0])^-1 mod r alongside a start pulse, where r = 2^W. The caller then pushes NDIG operand beats through a valid/ready stream. Each beat carries one digit of A, B and M at the same position. The operand side only accepts beats while the block is loading, so the caller must hold `op_valid` and the digits until `op_ready` is seen high at a clock edge. The result side offers a digit with `res_valid` and waits for `res_ready`. While a digit is stalled it is held unchanged, and no digit is dropped or repeated. Only one multiplication is in flight at a time. Computing the inverse digit and performing any final subtraction of M are left to the caller.

Top module: `mfr_mont_row`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `op_ready` and `res_valid` are low.
- R2: A `start` pulse seen while idle captures `inv_digit` and raises `op_ready` from the next cycle. Exactly NDIG operand beats are then accepted, least significant digit first. After the last beat `op_ready` falls.
- R3: A `start` pulse seen while `busy` is high has no effect. It changes neither the running result nor `op_ready`.
- R4: Pass i computes q = ((P[0] + A[i]*B[0]) * w) mod r and then P := (P + A[i]*B + q*M) / r. The division is exact, so the low digit of the sum at position 0 is always zero.
- R5: Exactly NDIG+1 passes run, and the last one uses A digit zero. The result equals the integer value of that recurrence. It is congruent to A*B*r^-(NDIG+1) mod M, and it is below 2M whenever B < 2M.
- R6: Every inter-digit carry stays at or below 2(r-1). The carry out of the top partial-product position is zero.
- R7: `res_valid` first goes high exactly (NDIG+1)*(NDIG+2) clock edges after the edge that accepts the final operand beat.
- R8: The result is NDIG+1 digits, least significant first. `res_last` is high with the final digit only.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_last` hold their values on the next cycle.
- R10: After the handshake of the digit marked `res_last`, `busy` and `res_valid` are low on the next cycle, and a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (honoured only when idle) |
| inv_digit | input | W | (r - M[0])^-1 mod r, captured with start |
| busy | output | 1 | High from start until the final result digit is taken |
| op_valid | input | 1 | Operand beat offered |
| op_ready | output | 1 | Operand beat accepted at this edge if valid |
| op_a | input | W | Digit of A |
| op_b | input | W | Digit of B |
| op_m | input | W | Digit of M |
| res_valid | output | 1 | Result digit offered |
| res_ready | input | 1 | Consumer takes the result digit |
| res_data | output | W | Result digit |
| res_last | output | 1 | Marks the top result digit |

## Verification
The operand stream is open from the cycle after start, and the first result digit is due exactly (NDIG+1)*(NDIG+2) edges after the final operand beat is taken. Each result digit moves on one edge after its handshake, and the block is idle one edge after the last digit. The bench keeps a free-running edge count. It drives inputs and reads outputs only on falling edges, so it records the edge at which each handshake happens. Each timing check compares the difference between two such edge numbers against the count above. Value checks use digits taken only on handshakes, so stalls injected on the result side cannot move a digit's position.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CALC = 2'd2,
    ST_EMIT = 2'd3
  } mfr_state_e;
endpackage

// File: rtl/mfr_qdigit.sv
// Quotient digit: q = ((p0 + a*b0) * w) mod r, all arithmetic truncated to W bits.
module mfr_qdigit #(
  parameter int W = 2
) (
  input  logic [W-1:0] p0,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] inv,
  output logic [W-1:0] q
);
  logic [W-1:0] low_sum;
  assign low_sum = p0 + a * b0;
  assign q       = low_sum * inv;
endmodule

// File: rtl/mfr_cell.sv
// One digit position: p + a*b + q*m + cin split into a kept digit and a carry.
module mfr_cell #(
  parameter int W = 2
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] q,
  input  logic [W-1:0] m,
  input  logic [W:0]   cin,
  output logic [W-1:0] dout,
  output logic [W:0]   cout
);
  localparam int SW = 2 * W + 1;
  logic [SW-1:0] s;
  assign s    = SW'(p) + SW'(a) * SW'(b) + SW'(q) * SW'(m) + SW'(cin);
  assign dout = s[W-1:0];
  assign cout = s[SW-1:W];
endmodule

// File: rtl/mfr_mont_row.sv
module mfr_mont_row
  import mfr_pkg::*;
#(
  parameter int W    = 2,
  parameter int NDIG = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] inv_digit,
  output logic         busy,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_m,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         res_last
);
  localparam int R     = 1 << W;
  localparam int NP    = NDIG + 2;
  localparam int NPASS = NDIG + 1;
  localparam int LW    = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int JW    = $clog2(NP);
  localparam int IW    = $clog2(NPASS);
  localparam int CMAX  = 2 * (R - 1);

  mfr_state_e st;
  logic [LW-1:0] ld_cnt;
  logic [JW-1:0] j;
  logic [IW-1:0] pass;
  logic [JW-1:0] k;

  logic [W-1:0] a_q [NDIG];
  logic [W-1:0] b_q [NDIG];
  logic [W-1:0] m_q [NDIG];
  logic [W-1:0] p_q [NP];
  logic [W-1:0] inv_q;
  logic [W-1:0] q_q;
  logic [W:0]   carry_q;

  // Zero-extended operand views
  logic [W-1:0] a_ext [NPASS];
  logic [W-1:0] b_ext [NP];
  logic [W-1:0] m_ext [NP];

  for (genvar g = 0; g < NPASS; g++) begin : g_aext
    if (g < NDIG) begin : g_real
      assign a_ext[g] = a_q[g];
    end else begin : g_pad
      assign a_ext[g] = '0;
    end
  end
  for (genvar g = 0; g < NP; g++) begin : g_bmext
    if (g < NDIG) begin : g_real
      assign b_ext[g] = b_q[g];
      assign m_ext[g] = m_q[g];
    end else begin : g_pad
      assign b_ext[g] = '0;
      assign m_ext[g] = '0;
    end
  end

  // Datapath
  logic [W-1:0] a_cur, q_new, q_use, dout;
  logic [W:0]   cin, cout;
  logic         first_digit, last_digit, last_pass, res_fire;

  assign a_cur       = a_ext[pass];
  assign first_digit = (j == '0);
  assign last_digit  = (j == JW'(NP - 1));
  assign last_pass   = (pass == IW'(NPASS - 1));
  assign q_use       = first_digit ? q_new : q_q;
  assign cin         = first_digit ? '0 : carry_q;

  mfr_qdigit #(.W(W)) u_qgen (
    .p0 (p_q[0]),
    .a  (a_cur),
    .b0 (b_ext[0]),
    .inv(inv_q),
    .q  (q_new)
  );

  mfr_cell #(.W(W)) u_cell (
    .p   (p_q[j]),
    .a   (a_cur),
    .b   (b_ext[j]),
    .q   (q_use),
    .m   (m_ext[j]),
    .cin (cin),
    .dout(dout),
    .cout(cout)
  );

  assign busy      = (st != ST_IDLE);
  assign op_ready  = (st == ST_LOAD);
  assign res_valid = (st == ST_EMIT);
  assign res_data  = p_q[k];
  assign res_last  = res_valid && (k == JW'(NDIG));
  assign res_fire  = res_valid && res_ready;

  // Control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ld_cnt <= '0;
      j      <= '0;
      pass   <= '0;
      k      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_LOAD;
          ld_cnt <= '0;
        end
        ST_LOAD: if (op_valid) begin
          if (ld_cnt == LW'(NDIG - 1)) begin
            st   <= ST_CALC;
            j    <= '0;
            pass <= '0;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        ST_CALC: begin
          if (last_digit) begin
            j <= '0;
            if (last_pass) begin
              st <= ST_EMIT;
              k  <= '0;
            end else begin
              pass <= pass + 1'b1;
            end
          end else begin
            j <= j + 1'b1;
          end
        end
        ST_EMIT: if (res_ready) begin
          if (k == JW'(NDIG)) st <= ST_IDLE;
          else                k  <= k + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Operand and partial-product storage (feedback path writes one digit lower)
  always_ff @(posedge clk) begin
    if (st == ST_IDLE && start) begin
      inv_q <= inv_digit;
      for (int x = 0; x < NP; x++) p_q[x] <= '0;
    end
    if (op_ready && op_valid) begin
      a_q[ld_cnt] <= op_a;
      b_q[ld_cnt] <= op_b;
      m_q[ld_cnt] <= op_m;
    end
    if (st == ST_CALC) begin
      carry_q <= cout;
      if (first_digit) q_q <= q_new;
      else             p_q[j - JW'(1)] <= dout;
      if (last_digit)  p_q[NP-1] <= cout[W-1:0];
    end
  end

  // Assertions
  a_r4_low_digit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CALC && first_digit) |-> (dout == '0));

  a_r6_carry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CALC) |-> (cout <= (W+1)'(CMAX)));

  a_r6_top_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CALC && last_digit) |-> (cout == '0));

  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_last)));

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && res_last) |=> (!busy && !res_valid));

  a_r3_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(res_fire && res_last)) |=> busy);

  a_r2_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_ready) |-> $past(start));
endmodule

// File: tb/mfr_mont_row_test.sv
module mfr_mont_row_test;
  localparam int W    = 2;
  localparam int N    = 2;
  localparam int R    = 1 << W;
  localparam int LAT  = (N + 1) * (N + 2);
  localparam int LIM  = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] inv_digit = '0;
  logic         busy;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [W-1:0] op_a = '0, op_b = '0, op_m = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [W-1:0] res_data;
  logic         res_last;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mfr_mont_row #(.W(W), .NDIG(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_digit(inv_digit), .busy(busy),
    .op_valid(op_valid), .op_ready(op_ready), .op_a(op_a), .op_b(op_b), .op_m(op_m),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_last(res_last)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > LIM) begin
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, LIM);
    summary();
  end

  function automatic int inv_of(input int m);
    for (int x = 0; x < R; x++) if ((((R - (m % R)) * x) % R) == 1) return x;
    return 0;
  endfunction

  // Recurrence of R4/R5, computed on integers
  function automatic int mont_model(input int a, input int b, input int m, input int w);
    int p = 0;
    for (int i = 0; i <= N; i++) begin
      int ai = (a >> (W * i)) % R;
      int q  = (((p % R) + ai * (b % R)) * w) % R;
      p = (p + ai * b + q * m) / R;
    end
    return p;
  endfunction

  task automatic run_op(input int a, input int b, input int m,
                        input bit gaps, input bit bp, input bit inject);
    int w, beat, last_edge, got, dig, held;
    bit rdy, stalled;
    w = inv_of(m);
    @(negedge clk);
    start = 1'b1; inv_digit = W'(w);
    @(negedge clk);
    start = 1'b0;
    check("R2 op_ready after start", op_ready, 1);
    beat = 0; last_edge = 0;
    while (beat < N) begin
      if (gaps && ((cyc + beat) % 3 == 0)) begin
        op_valid = 1'b0;
      end else begin
        op_valid = 1'b1;
        op_a = W'(a >> (W * beat));
        op_b = W'(b >> (W * beat));
        op_m = W'(m >> (W * beat));
        if (op_ready) begin
          beat++;
          if (beat == N) last_edge = cyc + 1;
        end
      end
      @(negedge clk);
    end
    op_valid = 1'b0;
    check("R2 op_ready low after last beat", op_ready, 0);
    if (inject) begin
      start = 1'b1; inv_digit = W'(w ^ 1);
      @(negedge clk);
      start = 1'b0;
      check("R3 start while busy keeps op_ready low", op_ready, 0);
    end
    while (!res_valid) @(negedge clk);
    check("R7 latency to first result digit", cyc - last_edge, LAT);
    got = 0; dig = 0; stalled = 1'b0; held = 0;
    while (dig <= N) begin
      if (stalled) check("R9 data held while stalled", res_data, held);
      rdy = bp ? ((cyc % 3) == 0) : 1'b1;
      res_ready = rdy;
      if (res_valid && rdy) begin
        got = got | (int'(res_data) << (W * dig));
        check("R8 last flag position", res_last, (dig == N) ? 1 : 0);
        dig++;
        stalled = 1'b0;
      end else begin
        stalled = res_valid;
        held = res_data;
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    check("R10 idle after last digit", busy, 0);
    check("R10 res_valid low after last digit", res_valid, 0);
    check("R5 result value (R4 recurrence)", got, mont_model(a, b, m, w));
    check("R5 congruence", (got * (R ** (N + 1))) % m, (a * b) % m);
    check("R5 bound below 2M", (got < 2 * m) ? 1 : 0, 1);
  endtask

  initial begin
    int cnt;
    #1;
    check("R1 busy in reset", busy, 0);
    check("R1 op_ready in reset", op_ready, 0);
    check("R1 res_valid in reset", res_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 res_valid after reset", res_valid, 0);
    cnt = 0;
    for (int m = 1; m < R ** N; m += 2) begin
      for (int a = 0; a < R ** N; a++) begin
        for (int b = 0; b < ((2 * m < R ** N) ? 2 * m : R ** N); b++) begin
          run_op(a, b, m, (cnt % 3) == 0, (cnt % 5) == 1, (cnt % 7) == 3);
          cnt++;
        end
      end
    end
    summary();
  end
endmodule